// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Port with Peripheral Override

This block is one general-purpose I/O port of eight pins. Each pin is a tri-state pad with three signals: a value to drive, a drive enable and the level sensed at the pin. Software reaches the port through a small register interface. That interface holds a data latch, which can be written a byte at a time under a per-bit mask or one bit at a time. It also holds a per-pin output-mode register, which chooses between push-pull and open-drain.

An allocation mask from outside can hand any pin to a digital peripheral. The peripheral then supplies the pin's value, its enable and an "is input" flag, and the latch no longer reaches that pin. A single global routing-enable input holds every driver off until routing is switched on. Some peripheral lines must never be driven high, so a per-pin force input makes those pins open-drain whatever the mode bit says.

Reads come from one of two places. A normal read of the data register returns the synchronized pad levels. A read flagged as the read half of a read-modify-write returns the latch contents instead.

Top module: `gpio_port_slice`

## Requirements
- R1: While `route_en` is 0, `pad_oe` is 0 on every pin, whatever the latch, mode, allocation and peripheral inputs hold.
- R2: The value source of a pin is its latch bit when its `alloc` bit is 0, and its `per_out` bit when its `alloc` bit is 1. Writes to the latch bit of an allocated pin change nothing at that pin.
- R3: With `rd_sel`=0 and `rmw_read`=0, `rd_data` returns the `pad_in` value sampled two rising edges earlier, through a two-flop synchronizer, for allocated and unallocated pins alike.
- R4: With `rd_sel`=0 and `rmw_read`=1, `rd_data` returns the data-latch contents.
- R5: A mode bit of 1 selects push-pull, so the pin is driven (`pad_oe`=1) with `pad_out` equal to the source. A mode bit of 0 selects open-drain: a source of 0 is driven low, and a source of 1 releases the pin (`pad_oe`=0). `pad_out` is 0 whenever `pad_oe` is 0.
- R6: A pin whose `force_od` bit is 1 behaves as open-drain whatever its mode bit holds. This applies whether the pin is allocated or not.
- R7: An allocated pin has its driver off when its `per_is_in` bit is 1 or its `per_oe` bit is 0, whatever the latch and mode bits hold.
- R8: Synchronous reset sets every mode bit to 0 (open-drain), every latch bit to 1 and both synchronizer stages to 0.
- R9: A byte write (`wr_en`=1) goes to the latch when `wr_sel`=0 and to the mode register when `wr_sel`=1. It changes only the bits set in `wr_mask`, each to the matching bit of `wr_data`. With no write, both registers hold their values.
- R10: A bit write (`bit_wr_en`=1) sets latch bit `bit_idx` to `bit_val` and leaves the other latch bits alone. When a bit write and a latch byte write fall in the same cycle, the bit write decides its own bit.
- R11: With `rd_sel`=1, `rd_data` returns the mode register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| route_en | input | 1 | Global routing enable; 0 turns every driver off |
| wr_en | input | 1 | Byte write strobe |
| wr_sel | input | 1 | Write target: 0 data latch, 1 mode register |
| wr_data | input | 8 | Byte write data |
| wr_mask | input | 8 | Per-bit write mask for byte writes |
| bit_wr_en | input | 1 | Single-bit latch write strobe |
| bit_idx | input | 3 | Latch bit selected by a bit write |
| bit_val | input | 1 | Value written by a bit write |
| rd_sel | input | 1 | Read source: 0 data, 1 mode register |
| rmw_read | input | 1 | Read-modify-write flag: data reads return the latch |
| rd_data | output | 8 | Read data |
| alloc | input | 8 | Per-pin peripheral ownership mask |
| per_out | input | 8 | Peripheral output values |
| per_oe | input | 8 | Peripheral output enables |
| per_is_in | input | 8 | Peripheral input-function flags |
| force_od | input | 8 | Per-pin forced open-drain |
| pad_in | input | 8 | Sensed pad levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad drive enables |

## Verification
The pad checks assume that the allocation, peripheral and force inputs are plain levels that settle within a cycle, so the pad outputs can be checked against them combinationally in the same cycle. The read-path property assumes that `pad_in` is sampled on clock edges. It also assumes that at least two edges have passed since reset, which the checker counts for itself. The bench changes every input only at the falling edge and keeps `route_en` high most of the time, so the drive rules are exercised often. It also mixes latch and bit writes in the same cycle on purpose.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    typedef enum logic {
        SEL_DATA = 1'b0,
        SEL_MODE = 1'b1
    } reg_sel_e;

    // Request for one pin, formed before the global gate and drive rule.
    typedef struct packed {
        logic src;        // value the pin should carry
        logic want_drive; // owner wants the driver on
        logic open_drain; // effective open-drain selection
    } pin_req_t;

    typedef struct packed {
        logic oe;
        logic out;
    } pin_drv_t;

    function automatic pin_drv_t resolve_pin(pin_req_t r, logic global_en);
        pin_drv_t d;
        d.oe  = global_en & r.want_drive & (~r.src | ~r.open_drain);
        d.out = d.oe & r.src;
        return d;
    endfunction

    function automatic logic merge_bit(logic cur, logic nv, logic en);
        return en ? nv : cur;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= d;
    end

    for (genvar k = 1; k < STAGES; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage_q[k] <= '0;
            else     stage_q[k] <= stage_q[k-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int W  = 8,
    parameter int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  reg_sel_e      wr_sel,
    input  logic [W-1:0]  wr_data,
    input  logic [W-1:0]  wr_mask,
    input  logic          bit_wr_en,
    input  logic [IW-1:0] bit_idx,
    input  logic          bit_val,
    output logic [W-1:0]  latch_q,
    output logic [W-1:0]  mode_q
);
    logic [W-1:0] latch_nx;
    logic [W-1:0] mode_nx;
    logic         wr_latch;
    logic         wr_mode;

    assign wr_latch = wr_en && (wr_sel == SEL_DATA);
    assign wr_mode  = wr_en && (wr_sel == SEL_MODE);

    always_comb begin
        for (int i = 0; i < W; i++) begin
            latch_nx[i] = merge_bit(latch_q[i], wr_data[i], wr_latch & wr_mask[i]);
            // the single-bit write decides its own bit
            latch_nx[i] = merge_bit(latch_nx[i], bit_val,
                                    bit_wr_en && (int'(bit_idx) == i));
            mode_nx[i]  = merge_bit(mode_q[i], wr_data[i], wr_mode & wr_mask[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '1;
            mode_q  <= '0;
        end else begin
            latch_q <= latch_nx;
            mode_q  <= mode_nx;
        end
    end
endmodule

// File: rtl/gpio_pin_drv.sv
module gpio_pin_drv
    import gpio_pkg::*;
(
    input  logic route_en,
    input  logic latch_bit,
    input  logic mode_bit,
    input  logic alloc,
    input  logic per_out,
    input  logic per_oe,
    input  logic per_is_in,
    input  logic force_od,
    output logic pad_out,
    output logic pad_oe
);
    pin_req_t req;
    pin_drv_t drv;

    always_comb begin
        req.src        = alloc ? per_out : latch_bit;
        req.want_drive = alloc ? (per_oe & ~per_is_in) : 1'b1;
        req.open_drain = force_od | ~mode_bit;
        drv            = resolve_pin(req, route_en);
    end

    assign pad_out = drv.out;
    assign pad_oe  = drv.oe;
endmodule

// File: rtl/gpio_port_slice.sv
module gpio_port_slice
    import gpio_pkg::*;
#(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2,
    localparam int IW         = (W > 1) ? $clog2(W) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          route_en,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic [W-1:0]  wr_data,
    input  logic [W-1:0]  wr_mask,
    input  logic          bit_wr_en,
    input  logic [IW-1:0] bit_idx,
    input  logic          bit_val,
    input  logic          rd_sel,
    input  logic          rmw_read,
    output logic [W-1:0]  rd_data,
    input  logic [W-1:0]  alloc,
    input  logic [W-1:0]  per_out,
    input  logic [W-1:0]  per_oe,
    input  logic [W-1:0]  per_is_in,
    input  logic [W-1:0]  force_od,
    input  logic [W-1:0]  pad_in,
    output logic [W-1:0]  pad_out,
    output logic [W-1:0]  pad_oe
);
    logic [W-1:0] latch_q;
    logic [W-1:0] mode_q;
    logic [W-1:0] pin_sync;
    reg_sel_e     wr_sel_e;
    reg_sel_e     rd_sel_e;

    assign wr_sel_e = reg_sel_e'(wr_sel);
    assign rd_sel_e = reg_sel_e'(rd_sel);

    gpio_regs #(.W(W), .IW(IW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel_e),
        .wr_data   (wr_data),
        .wr_mask   (wr_mask),
        .bit_wr_en (bit_wr_en),
        .bit_idx   (bit_idx),
        .bit_val   (bit_val),
        .latch_q   (latch_q),
        .mode_q    (mode_q)
    );

    gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (pin_sync)
    );

    for (genvar i = 0; i < W; i++) begin : g_pin
        gpio_pin_drv u_drv (
            .route_en  (route_en),
            .latch_bit (latch_q[i]),
            .mode_bit  (mode_q[i]),
            .alloc     (alloc[i]),
            .per_out   (per_out[i]),
            .per_oe    (per_oe[i]),
            .per_is_in (per_is_in[i]),
            .force_od  (force_od[i]),
            .pad_out   (pad_out[i]),
            .pad_oe    (pad_oe[i])
        );
    end

    always_comb begin
        unique case (rd_sel_e)
            SEL_MODE: rd_data = mode_q;
            default:  rd_data = rmw_read ? latch_q : pin_sync;
        endcase
    end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         route_en,
    input logic         wr_en,
    input logic         wr_sel,
    input logic         bit_wr_en,
    input logic         rd_sel,
    input logic         rmw_read,
    input logic [W-1:0] rd_data,
    input logic [W-1:0] alloc,
    input logic [W-1:0] per_oe,
    input logic [W-1:0] per_is_in,
    input logic [W-1:0] force_od,
    input logic [W-1:0] pad_in,
    input logic [W-1:0] pad_out,
    input logic [W-1:0] pad_oe,
    input logic [W-1:0] latch_q,
    input logic [W-1:0] mode_q
);
    // edges since reset release, saturating; gates the read-latency property
    logic [1:0] settle_q;
    always_ff @(posedge clk) begin
        if (rst)                settle_q <= '0;
        else if (settle_q != 2'd3) settle_q <= settle_q + 2'd1;
    end

    p_drivers_off_r1: assert property (@(posedge clk) disable iff (rst)
        !route_en |-> (pad_oe == '0));

    p_sync_path_r3: assert property (@(posedge clk) disable iff (rst)
        (settle_q >= 2'd2 && !rd_sel && !rmw_read) |-> (rd_data == $past(pad_in, 2)));

    p_rmw_latch_r4: assert property (@(posedge clk) disable iff (rst)
        (!rd_sel && rmw_read) |-> (rd_data == latch_q));

    p_od_no_high_r5: assert property (@(posedge clk) disable iff (rst)
        (pad_oe & pad_out & ~mode_q) == '0);

    p_forced_od_r6: assert property (@(posedge clk) disable iff (rst)
        (pad_oe & pad_out & force_od) == '0);

    p_input_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (pad_oe & alloc & (per_is_in | ~per_oe)) == '0);

    p_reset_vals_r8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mode_q == '0 && latch_q == '1));

    p_latch_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!(wr_en && !wr_sel) && !bit_wr_en) |=> $stable(latch_q));

    p_mode_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_sel) |=> $stable(mode_q));

    p_mode_read_r11: assert property (@(posedge clk) disable iff (rst)
        rd_sel |-> (rd_data == mode_q));
endmodule

bind gpio_port_slice gpio_port_chk #(.W(W)) u_chk (.*);

// File: tb/gpio_port_slice_test.sv
module gpio_port_slice_test;
    localparam int  W          = 8;
    localparam time CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst;
    logic         route_en, wr_en, wr_sel, bit_wr_en, bit_val, rd_sel, rmw_read;
    logic [W-1:0] wr_data, wr_mask, alloc, per_out, per_oe, per_is_in, force_od, pad_in;
    logic [2:0]   bit_idx;
    logic [W-1:0] rd_data, pad_out, pad_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [W-1:0] m_latch, m_mode, m_s1, m_s2;

    gpio_port_slice uut (
        .clk(clk), .rst(rst), .route_en(route_en), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .wr_mask(wr_mask), .bit_wr_en(bit_wr_en), .bit_idx(bit_idx),
        .bit_val(bit_val), .rd_sel(rd_sel), .rmw_read(rmw_read), .rd_data(rd_data),
        .alloc(alloc), .per_out(per_out), .per_oe(per_oe), .per_is_in(per_is_in),
        .force_od(force_od), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [W-1:0] exp_oe();
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) begin
            logic src, want, od;
            src  = alloc[i] ? per_out[i] : m_latch[i];
            want = alloc[i] ? (per_oe[i] && !per_is_in[i]) : 1'b1;
            od   = force_od[i] || !m_mode[i];
            r[i] = route_en && want && (!src || !od);
        end
        return r;
    endfunction

    function automatic logic [W-1:0] exp_out();
        logic [W-1:0] r;
        logic [W-1:0] oe;
        oe = exp_oe();
        for (int i = 0; i < W; i++)
            r[i] = oe[i] && (alloc[i] ? per_out[i] : m_latch[i]);
        return r;
    endfunction

    function automatic logic [W-1:0] exp_rd();
        if (rd_sel)   return m_mode;
        if (rmw_read) return m_latch;
        return m_s2;
    endfunction

    task automatic check(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic verify(string tag);
        #1;
        check(tag, "pad_oe",  pad_oe,  exp_oe());
        check(tag, "pad_out", pad_out, exp_out());
        check(tag, "rd_data", rd_data, exp_rd());
    endtask

    // model the rising edge, then move to the next falling edge
    task automatic advance();
        for (int i = 0; i < W; i++) begin
            if (wr_en && !wr_sel && wr_mask[i]) m_latch[i] = wr_data[i];
            if (wr_en &&  wr_sel && wr_mask[i]) m_mode[i]  = wr_data[i];
        end
        if (bit_wr_en) m_latch[bit_idx] = bit_val;
        m_s2 = m_s1;
        m_s1 = pad_in;
        @(negedge clk);
    endtask

    task automatic idle();
        wr_en = 0; wr_sel = 0; wr_data = '0; wr_mask = '0;
        bit_wr_en = 0; bit_idx = '0; bit_val = 0;
    endtask

    task automatic byte_wr(logic sel, logic [W-1:0] d, logic [W-1:0] m);
        wr_en = 1; wr_sel = sel; wr_data = d; wr_mask = m;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'h1C0DE);
        rst = 1; route_en = 0; rd_sel = 0; rmw_read = 0;
        alloc = '0; per_out = '0; per_oe = '0; per_is_in = '0; force_od = '0; pad_in = '0;
        idle();
        repeat (3) @(negedge clk);
        rst = 0;
        m_latch = '1; m_mode = '0; m_s1 = '0; m_s2 = '0;

        // R8: reset values
        rd_sel = 1; verify("R8");
        check("R8", "mode after reset", rd_data, 8'h00);
        rd_sel = 0; rmw_read = 1; #1;
        check("R8", "latch after reset", rd_data, 8'hFF);
        // R5: open-drain with latch ones releases all pins
        route_en = 1; verify("R5");
        check("R5", "released after reset", pad_oe, 8'h00);
        advance();

        // R9: masked writes to latch and mode
        byte_wr(0, 8'hA5, 8'h0F); verify("R9"); advance();
        idle(); rmw_read = 1; rd_sel = 0; verify("R9");
        check("R9", "masked latch", rd_data, 8'hF5);
        byte_wr(1, 8'h3C, 8'hF0); advance();
        idle(); rd_sel = 1; verify("R11");
        check("R11", "mode read", rd_data, 8'h30);

        // R1: route off means no drive even with push-pull and zeros
        byte_wr(1, 8'hFF, 8'hFF); advance();
        byte_wr(0, 8'h00, 8'hFF); advance();
        idle(); route_en = 0; verify("R1");
        check("R1", "all off", pad_oe, 8'h00);
        route_en = 1; verify("R5");
        check("R5", "push-pull low", pad_oe, 8'hFF);

        // R10: bit write wins over same-cycle byte write
        byte_wr(0, 8'h00, 8'hFF); bit_wr_en = 1; bit_idx = 3'd7; bit_val = 1; advance();
        idle(); rd_sel = 0; rmw_read = 1; verify("R10");
        check("R10", "bit wins", rd_data, 8'h80);
        bit_wr_en = 1; bit_idx = 3'd2; bit_val = 1; advance();
        idle(); verify("R10");
        check("R10", "single bit", rd_data, 8'h84);

        // R2: allocated pins ignore latch writes
        alloc = 8'h0F; per_out = 8'h0A; per_oe = 8'hFF;
        byte_wr(0, 8'h05, 8'hFF); advance();
        idle(); verify("R2");
        check("R2", "peripheral source", pad_out & 8'h0F, 8'h0A);

        // R6: forced open-drain overrides push-pull
        force_od = 8'h0F; verify("R6");
        check("R6", "forced od oe", pad_oe & 8'h0F, 8'h05);

        // R7: peripheral input function turns driver off
        force_od = '0; per_is_in = 8'h03; per_oe = 8'hFB; verify("R7");
        check("R7", "input pins off", pad_oe & 8'h0F, 8'h08);
        per_is_in = '0; per_oe = '0;

        // R3: pin read latency of two edges, also on allocated pins
        rmw_read = 0; rd_sel = 0; pad_in = 8'h3C; verify("R3"); advance();
        pad_in = 8'hC3; verify("R3"); advance();
        verify("R3");
        check("R3", "two-edge latency", rd_data, 8'h3C);
        advance(); verify("R3");
        check("R3", "next sample", rd_data, 8'hC3);
        rmw_read = 1; verify("R4");
        check("R4", "rmw returns latch", rd_data, m_latch);
        alloc = '0;

        // random mix
        for (int n = 0; n < 4000; n++) begin
            route_en  = ($urandom % 8) != 0;
            wr_en     = $urandom % 2; wr_sel = $urandom % 2;
            wr_data   = W'($urandom); wr_mask = W'($urandom);
            bit_wr_en = ($urandom % 3) == 0; bit_idx = 3'($urandom); bit_val = $urandom % 2;
            rd_sel    = ($urandom % 4) == 0; rmw_read = $urandom % 2;
            alloc     = W'($urandom); per_out = W'($urandom); per_oe = W'($urandom);
            per_is_in = W'($urandom) & W'($urandom); force_od = W'($urandom) & W'($urandom);
            pad_in    = W'($urandom);
            verify(rd_sel ? "R11" : (rmw_read ? "R4" : "R3"));
            advance();
        end
        finish_run();
    end
endmodule